// File: doc/BRIEF.md
# Clock Output Power-Down Sequencer

This block sits in front of the output drivers of a multi-output clock generator. It decides when the single-ended and differential clocks may run, and when the crystal oscillator and the PLL may be switched off. One shared input pin carries two meanings over the life of the part. After reset it is read only as a power-good qualifier. Once it has been seen high, it becomes an active-low power-down request.

A power-down request passes through a two-flop synchronizer on the reference clock and a two-deep low detector. The request is accepted only when it reads low on two consecutive reference edges; a shorter dip is dropped. The sequencer then closes every output gate, each on a falling edge of that output's own clock. Once every gate reports closed, it asserts the oscillator and PLL shutdown controls. In the stopped state, a strap input selects whether the differential pairs are held low or released to high impedance.

On release, the PLL is powered, lock is awaited (with a timeout flag), and each output gate reopens on its own clock. While the PLL is locking, strapped differential pairs are driven to a parked high level. A 3-bit status output reports the sequencer state.

Top module: `clkout_pd_seq`

## Requirements
- R1: While reset is asserted and just after it, state_o is 0 (waiting for power-good), osc_pd_o and pll_pd_o are 1, lock_err_o is 0 and all single-ended outputs are low.
- R2: In the power-good wait state, a high level driven on pgood_pdn_i is taken as power-good. state_o becomes 4 (waiting for lock) on the third rising reference edge after the pin rises, and pll_pd_o and osc_pd_o drop to 0 in that same cycle.
- R3: pll_lock_i is synchronized by two flops. state_o becomes 5 (enabling) on the third rising reference edge after lock rises, and becomes 1 (running) once every output gate has opened. After that, every single-ended and differential output toggles.
- R4: In the running state, a request held low moves state_o to 2 (stopping) on the fifth rising reference edge after the pin falls. A low lasting only one reference cycle leaves state_o at 1.
- R5: Single-ended outputs stop only at a falling edge of their own clock, so no output ever falls while its input clock is high.
- R6: state_o becomes 3 (powered down) only from 2 or 4. On entering 3 from the stopping state, every output is already stopped. pll_pd_o and osc_pd_o are 1 only in states 0 and 3.
- R7: In the powered-down state with diff_hiz_strap_i = 0, each differential pair has diff_oe_o = 1 and diff_p_o = diff_n_o = 0. With the strap at 1, diff_oe_o = 0.
- R8: With the strap at 1, in states 4 and 5 until a pair's gate opens, that pair has diff_oe_o = 1, diff_p_o = 1 and diff_n_o = 0.
- R9: In the powered-down state, the pin going high moves state_o to 4 on the third rising reference edge after it rises.
- R10: If lock is absent for LOCK_TIMEOUT reference cycles in state 4, lock_err_o rises exactly LOCK_TIMEOUT cycles after entry and the outputs stay stopped. lock_err_o falls when the state leaves 4.
- R11: state_o encodes 0 wait power-good, 1 run, 2 stopping, 3 powered down, 4 wait lock, 5 enabling. No other value appears.
- R12: A request held low during state 4 moves state_o to 3 on the fifth rising reference edge after the pin falls, without any output starting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock for synchronizers and sequencer |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pgood_pdn_i | input | 1 | Shared pin: power-good first, then active-low power-down request |
| diff_hiz_strap_i | input | 1 | 1: stopped differential pairs go high impedance; 0: driven low |
| pll_lock_i | input | 1 | PLL lock flag (asynchronous) |
| se_clk_i | input | N_SE | Free-running single-ended output clocks |
| diff_clk_i | input | N_DIFF | Free-running differential output clocks |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| diff_p_o | output | N_DIFF | Differential true leg |
| diff_n_o | output | N_DIFF | Differential complement leg |
| diff_oe_o | output | N_DIFF | Differential driver enable |
| osc_pd_o | output | 1 | Oscillator shutdown |
| pll_pd_o | output | 1 | PLL shutdown |
| lock_err_o | output | 1 | Lock timeout flag |
| state_o | output | 3 | Sequencer state |

## Verification
Results tied to a pin edge have fixed latencies, counted in reference cycles from the negative edge on which the stimulus is driven. The new state is due on the third edge after a release, a power-good or a lock. It is due on the fifth edge after a held low request. The timeout flag is due exactly LOCK_TIMEOUT edges after the lock wait begins. The bench queues each expectation with its due cycle and compares it on the falling edge of that cycle, including the cycle just before, so a result that comes one cycle early or late is reported. Gate-dependent steps (stopping done, enabling done) depend on several unrelated clocks, so they are polled with a bound. A continuous monitor catches any single-ended output that falls while its clock is still high.

// File: rtl/clkout_pd_pkg.sv
package clkout_pd_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_PGOOD = 3'd0,
    ST_RUN        = 3'd1,
    ST_STOPPING   = 3'd2,
    ST_PWR_DOWN   = 3'd3,
    ST_WAIT_LOCK  = 3'd4,
    ST_ENABLING   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/clkout_pd_req_qual.sv
module clkout_pd_req_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic lock_i,
  output logic req_hi_o,
  output logic req_low2_o,
  output logic lock_o
);
  logic [1:0] req_sync_q;
  logic [1:0] lock_sync_q;
  logic [1:0] low_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_sync_q  <= '0;
      lock_sync_q <= '0;
      low_sh_q    <= '0;
    end else begin
      req_sync_q  <= {req_sync_q[0], pin_i};
      lock_sync_q <= {lock_sync_q[0], lock_i};
      low_sh_q    <= {low_sh_q[0], req_sync_q[1]};
    end
  end

  assign req_hi_o   = req_sync_q[1];
  // two consecutive low samples of the synchronized request
  assign req_low2_o = ~|low_sh_q;
  assign lock_o     = lock_sync_q[1];
endmodule

// File: rtl/clkout_pd_gate.sv
module clkout_pd_gate (
  input  logic out_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic run_en_i,
  output logic en_o,
  output logic ack_o
);
  logic en_meta_q;
  logic ack_meta_q;

  // enable changes only while the output clock is low
  always_ff @(negedge out_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_meta_q <= 1'b0;
      en_o      <= 1'b0;
    end else begin
      en_meta_q <= run_en_i;
      en_o      <= en_meta_q;
    end
  end

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_meta_q <= 1'b0;
      ack_o      <= 1'b0;
    end else begin
      ack_meta_q <= en_o;
      ack_o      <= ack_meta_q;
    end
  end
endmodule

// File: rtl/clkout_pd_fsm.sv
module clkout_pd_fsm
  import clkout_pd_pkg::*;
#(
  parameter int unsigned LOCK_TIMEOUT = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_hi_i,
  input  logic       req_low2_i,
  input  logic       lock_i,
  input  logic       all_on_i,
  input  logic       all_off_i,
  output seq_state_e state_o,
  output logic       run_en_o,
  output logic       pd_o,
  output logic       lock_err_o
);
  localparam int unsigned CNT_W = $clog2(LOCK_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_TIMEOUT);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_PGOOD: if (req_hi_i) state_d = ST_WAIT_LOCK;
      ST_RUN:        if (req_low2_i) state_d = ST_STOPPING;
      ST_STOPPING:   if (all_off_i) state_d = ST_PWR_DOWN;
      ST_PWR_DOWN:   if (req_hi_i) state_d = ST_WAIT_LOCK;
      ST_WAIT_LOCK: begin
        if (req_low2_i)  state_d = ST_PWR_DOWN;
        else if (lock_i) state_d = ST_ENABLING;
      end
      // finish opening before any new stop, so the gates are never half-open
      ST_ENABLING:   if (all_on_i) state_d = ST_RUN;
      default:       state_d = ST_WAIT_PGOOD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT_PGOOD;
      run_en_o <= 1'b0;
      cnt_q    <= '0;
    end else begin
      state_q  <= state_d;
      run_en_o <= (state_d == ST_RUN) || (state_d == ST_ENABLING);
      if (state_q != ST_WAIT_LOCK) cnt_q <= '0;
      else if (cnt_q != CNT_MAX)   cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign state_o    = state_q;
  assign pd_o       = (state_q == ST_WAIT_PGOOD) || (state_q == ST_PWR_DOWN);
  assign lock_err_o = (state_q == ST_WAIT_LOCK) && (cnt_q == CNT_MAX);
endmodule

// File: rtl/clkout_pd_seq.sv
module clkout_pd_seq
  import clkout_pd_pkg::*;
#(
  parameter int unsigned N_SE         = 4,
  parameter int unsigned N_DIFF       = 2,
  parameter int unsigned LOCK_TIMEOUT = 1024
) (
  input  logic              clk_ref_i,
  input  logic              rst_ni,
  input  logic              pgood_pdn_i,
  input  logic              diff_hiz_strap_i,
  input  logic              pll_lock_i,
  input  logic [N_SE-1:0]   se_clk_i,
  input  logic [N_DIFF-1:0] diff_clk_i,
  output logic [N_SE-1:0]   se_clk_o,
  output logic [N_DIFF-1:0] diff_p_o,
  output logic [N_DIFF-1:0] diff_n_o,
  output logic [N_DIFF-1:0] diff_oe_o,
  output logic              osc_pd_o,
  output logic              pll_pd_o,
  output logic              lock_err_o,
  output logic [2:0]        state_o
);
  localparam int unsigned N_TOT = N_SE + N_DIFF;

  logic             req_hi, req_low2, lock_s;
  logic             run_en, pd, park_hi;
  logic [N_TOT-1:0] gate_clk, gate_en, gate_ack;
  seq_state_e       state;

  clkout_pd_req_qual u_qual (
    .clk_i      (clk_ref_i),
    .rst_ni     (rst_ni),
    .pin_i      (pgood_pdn_i),
    .lock_i     (pll_lock_i),
    .req_hi_o   (req_hi),
    .req_low2_o (req_low2),
    .lock_o     (lock_s)
  );

  clkout_pd_fsm #(.LOCK_TIMEOUT(LOCK_TIMEOUT)) u_fsm (
    .clk_i      (clk_ref_i),
    .rst_ni     (rst_ni),
    .req_hi_i   (req_hi),
    .req_low2_i (req_low2),
    .lock_i     (lock_s),
    .all_on_i   (&gate_ack),
    .all_off_i  (~|gate_ack),
    .state_o    (state),
    .run_en_o   (run_en),
    .pd_o       (pd),
    .lock_err_o (lock_err_o)
  );

  assign gate_clk = {diff_clk_i, se_clk_i};

  for (genvar g = 0; g < N_TOT; g++) begin : g_gate
    clkout_pd_gate u_gate (
      .out_clk_i (gate_clk[g]),
      .ref_clk_i (clk_ref_i),
      .rst_ni    (rst_ni),
      .run_en_i  (run_en),
      .en_o      (gate_en[g]),
      .ack_o     (gate_ack[g])
    );
  end

  assign se_clk_o = se_clk_i & gate_en[N_SE-1:0];

  // strapped pairs park high while the PLL restarts
  assign park_hi = diff_hiz_strap_i &&
                   ((state == ST_WAIT_LOCK) || (state == ST_ENABLING));

  for (genvar d = 0; d < N_DIFF; d++) begin : g_diff
    logic en_d;
    assign en_d         = gate_en[N_SE+d];
    assign diff_p_o[d]  = en_d ? diff_clk_i[d] : park_hi;
    assign diff_n_o[d]  = en_d ? ~diff_clk_i[d] : 1'b0;
    assign diff_oe_o[d] = en_d | ~diff_hiz_strap_i | park_hi;
  end

  assign osc_pd_o = pd;
  assign pll_pd_o = pd;
  assign state_o  = state;
endmodule

// File: rtl/clkout_pd_seq_chk.sv
module clkout_pd_seq_chk #(
  parameter int unsigned N_SE   = 4,
  parameter int unsigned N_DIFF = 2
) (
  input logic              clk_ref_i,
  input logic              rst_ni,
  input logic              diff_hiz_strap_i,
  input logic [N_SE-1:0]   se_clk_o,
  input logic [N_DIFF-1:0] diff_p_o,
  input logic [N_DIFF-1:0] diff_n_o,
  input logic [N_DIFF-1:0] diff_oe_o,
  input logic              osc_pd_o,
  input logic              pll_pd_o,
  input logic              lock_err_o,
  input logic [2:0]        state_o
);
  // R6
  pd_outputs_stopped_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (state_o == 3'd3) |-> (se_clk_o == '0) && pll_pd_o && osc_pd_o);

  // R6
  pd_entry_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |->
      ($past(state_o) == 3'd2 || $past(state_o) == 3'd4));

  // R3
  run_entry_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (state_o == 3'd1 && $past(state_o) != 3'd1) |-> ($past(state_o) == 3'd5));

  // R4
  stop_entry_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (state_o == 3'd2 && $past(state_o) != 3'd2) |-> ($past(state_o) == 3'd1));

  // R7
  diff_hiz_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (state_o == 3'd3 && diff_hiz_strap_i) |-> (diff_oe_o == '0));

  // R7
  diff_low_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (state_o == 3'd3 && !diff_hiz_strap_i) |->
      (diff_oe_o == '1 && diff_p_o == '0 && diff_n_o == '0));

  // R8
  diff_park_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    (state_o == 3'd4 && diff_hiz_strap_i) |->
      (diff_oe_o == '1 && diff_p_o == '1 && diff_n_o == '0));

  // R10
  lock_err_stopped_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    lock_err_o |-> (state_o == 3'd4) && (se_clk_o == '0));

  // R11
  state_legal_chk: assert property (@(posedge clk_ref_i) disable iff (!rst_ni)
    state_o <= 3'd5);
endmodule

bind clkout_pd_seq clkout_pd_seq_chk #(.N_SE(N_SE), .N_DIFF(N_DIFF)) u_chk (
  .clk_ref_i        (clk_ref_i),
  .rst_ni           (rst_ni),
  .diff_hiz_strap_i (diff_hiz_strap_i),
  .se_clk_o         (se_clk_o),
  .diff_p_o         (diff_p_o),
  .diff_n_o         (diff_n_o),
  .diff_oe_o        (diff_oe_o),
  .osc_pd_o         (osc_pd_o),
  .pll_pd_o         (pll_pd_o),
  .lock_err_o       (lock_err_o),
  .state_o          (state_o)
);

// File: tb/clkout_pd_seq_tb_top.sv
module clkout_pd_seq_tb_top;
  localparam int N_SE = 4;
  localparam int N_DIFF = 2;
  localparam int T_LOCK = 16;
  localparam logic [2:0] S_WPG = 3'd0, S_RUN = 3'd1, S_STOP = 3'd2,
                         S_PD = 3'd3, S_WL = 3'd4, S_EN = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0, lock = 1'b0, strap = 1'b0;
  logic c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0, d0 = 1'b0, d1 = 1'b0;
  logic [N_SE-1:0]   se_ci;
  logic [N_DIFF-1:0] d_ci;
  logic [N_SE-1:0]   se_o;
  logic [N_DIFF-1:0] dp, dn, doe;
  logic osc_pd, pll_pd, err;
  logic [2:0] st;

  int cyc = 0, checks = 0, errs = 0, runt = 0;
  int due_q[$];
  logic [4:0] val_q[$];
  string tag_q[$];
  logic [N_SE-1:0] se_prev = '0;

  always #10 clk = ~clk;
  always #8  c0 = ~c0;
  always #11 c1 = ~c1;
  always #15 c2 = ~c2;
  always #13 c3 = ~c3;
  always #6  d0 = ~d0;
  always #9  d1 = ~d1;
  assign se_ci = {c3, c2, c1, c0};
  assign d_ci  = {d1, d0};

  clkout_pd_seq #(.N_SE(N_SE), .N_DIFF(N_DIFF), .LOCK_TIMEOUT(T_LOCK)) dut_i (
    .clk_ref_i(clk), .rst_ni(rst_n), .pgood_pdn_i(pin), .diff_hiz_strap_i(strap),
    .pll_lock_i(lock), .se_clk_i(se_ci), .diff_clk_i(d_ci), .se_clk_o(se_o),
    .diff_p_o(dp), .diff_n_o(dn), .diff_oe_o(doe), .osc_pd_o(osc_pd),
    .pll_pd_o(pll_pd), .lock_err_o(err), .state_o(st));

  always @(posedge clk) cyc <= cyc + 1;

  // R5: an output must never fall while its source clock is still high
  always @(se_o) begin
    for (int i = 0; i < N_SE; i++)
      if (se_prev[i] && !se_o[i] && se_ci[i]) runt++;
    se_prev = se_o;
  end

  // scoreboard monitor: {state, pll_pd, lock_err} due at a given cycle
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      int d;
      logic [4:0] v;
      string t;
      d = due_q.pop_front(); v = val_q.pop_front(); t = tag_q.pop_front();
      checks++;
      if (d != cyc || {st, pll_pd, err} !== v) begin
        errs++;
        $display("FAIL %s cyc=%0d: state=%0d pd=%0b err=%0b expected state=%0d pd=%0b err=%0b (due %0d)",
                 t, cyc, st, pll_pd, err, v[4:2], v[1], v[0], d);
      end
    end
  end

  task automatic push(input int d, input logic [2:0] s, input logic pd, input logic e,
                      input string t);
    due_q.push_back(d); val_q.push_back({s, pd, e}); tag_q.push_back(t);
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && due_q.size() > 0; i++) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string t, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic wait_state(input logic [2:0] s, input int lim, input string t);
    bit hit = 0;
    for (int i = 0; i < lim && !hit; i++) begin
      @(negedge clk);
      if (st == s) hit = 1;
    end
    chk(hit, t, 32'(st), 32'(s));
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #(20 * 20000);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    int c;
    logic [N_SE-1:0] seen_se;
    logic [N_DIFF-1:0] seen_p, seen_n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R11 reset state
    chk(st == S_WPG, "R1 state", 32'(st), 32'(S_WPG));
    chk(osc_pd && pll_pd, "R1 pd", {osc_pd, pll_pd}, 2'b11);
    chk(!err, "R1 err", 32'(err), 0);
    chk(se_o == '0, "R1 se", 32'(se_o), 0);

    // R2 power-good
    @(negedge clk); pin = 1'b1; c = cyc;
    push(c + 2, S_WPG, 1'b1, 1'b0, "R2");
    push(c + 3, S_WL, 1'b0, 1'b0, "R2");
    drain();

    // R3 lock and enable
    @(negedge clk); lock = 1'b1; c = cyc;
    push(c + 2, S_WL, 1'b0, 1'b0, "R3");
    push(c + 3, S_EN, 1'b0, 1'b0, "R3");
    drain();
    wait_state(S_RUN, 40, "R3 run");
    seen_se = '0; seen_p = '0; seen_n = '0;
    repeat (100) begin
      #3; seen_se |= se_o; seen_p |= dp; seen_n |= dn;
    end
    chk(seen_se == '1 && seen_p == '1 && seen_n == '1, "R3 toggle",
        {seen_se, seen_p, seen_n}, '1);

    // R4 one-cycle dip is ignored
    @(negedge clk); pin = 1'b0; c = cyc;
    @(negedge clk); pin = 1'b1;
    push(c + 5, S_RUN, 1'b0, 1'b0, "R4 cancel");
    push(c + 7, S_RUN, 1'b0, 1'b0, "R4 cancel");
    drain();

    // R4 held low, strap 0
    @(negedge clk); pin = 1'b0; c = cyc;
    push(c + 4, S_RUN, 1'b0, 1'b0, "R4");
    push(c + 5, S_STOP, 1'b0, 1'b0, "R4/R6");
    drain();
    wait_state(S_PD, 40, "R6 pd");
    chk(osc_pd && pll_pd, "R6 ctrl", {osc_pd, pll_pd}, 2'b11);
    chk(se_o == '0, "R5 stopped", 32'(se_o), 0);
    lock = 1'b0;
    repeat (5) @(negedge clk);
    chk(doe == '1 && dp == '0 && dn == '0, "R7 low", {doe, dp, dn}, {2'b11, 4'b0});

    // R7 strap to high impedance
    @(negedge clk); strap = 1'b1;
    @(negedge clk);
    chk(doe == '0, "R7 hiz", 32'(doe), 0);

    // R9 release, R8 park, R10 timeout
    @(negedge clk); pin = 1'b1; c = cyc;
    push(c + 2, S_PD, 1'b1, 1'b0, "R9");
    push(c + 3, S_WL, 1'b0, 1'b0, "R9");
    drain();
    chk(doe == '1 && dp == '1 && dn == '0, "R8 park", {doe, dp, dn}, {2'b11, 2'b11, 2'b00});
    push(c + 2 + T_LOCK, S_WL, 1'b0, 1'b0, "R10 early");
    push(c + 3 + T_LOCK, S_WL, 1'b0, 1'b1, "R10 flag");
    drain();
    chk(se_o == '0, "R10 stopped", 32'(se_o), 0);
    @(negedge clk); lock = 1'b1; c = cyc;
    push(c + 2, S_WL, 1'b0, 1'b1, "R10 hold");
    push(c + 3, S_EN, 1'b0, 1'b0, "R10 clear");
    drain();
    wait_state(S_RUN, 40, "R3 rerun");

    // R12 power-down during lock wait
    @(negedge clk); pin = 1'b0;
    wait_state(S_PD, 60, "R12 pd");
    lock = 1'b0;
    @(negedge clk); pin = 1'b1; c = cyc;
    push(c + 3, S_WL, 1'b0, 1'b0, "R12");
    drain();
    @(negedge clk); pin = 1'b0; c = cyc;
    push(c + 4, S_WL, 1'b0, 1'b0, "R12");
    push(c + 5, S_PD, 1'b1, 1'b0, "R12");
    drain();
    chk(se_o == '0, "R12 stopped", 32'(se_o), 0);

    // R5 no shortened pulse across the whole run
    chk(runt == 0, "R5 runt", 32'(runt), 0);
    report();
    $finish;
  end
endmodule